// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small fixed-point DSP datapath. It takes a 48-bit accumulator value and a 48-bit product value, plus a 4-bit operation code, and forms a 48-bit result in the same cycle. Most operations work on the low 32 bits and pass the accumulator's top 16 bits through. One addition spans the full 48 bits, so long products can be summed without loss.

Alongside the result, the block keeps four status flags in a register: carry, zero, sign and overflow. Carry, zero and sign take their new values whenever an active operation is enabled. Overflow is sticky: operations can only set it, and a dedicated synchronous clear input resets it. When the result is written back to the accumulator is left to the surrounding sequencer.

Top module: `acc_flag_alu`

## Requirements
- R1: Codes 1 (AND), 2 (OR) and 3 (XOR) combine accumulator bits 31..0 with product bits 31..0. Carry becomes 0. Zero is set when the 32-bit result is 0, and sign is taken from result bit 31.
- R2: Code 4 (ADD) forms the 33-bit sum of the two low 32-bit operands and takes carry from sum bit 32. Overflow is set when both operands have the same bit 31 and the result's bit 31 differs from it.
- R3: Code 5 (SUB) forms the 33-bit difference accumulator minus product on the low 32 bits and takes carry (borrow) from difference bit 32. Overflow is set when the operands' bits 31 differ and the result's bit 31 differs from the accumulator's bit 31.
- R4: Code 6 adds the full 48-bit operands. Carry comes from sum bit 48 and overflow from the bit-47 same-sign rule. Zero and sign are taken from the 48-bit result, and all 48 result bits come from the sum.
- R5: Code 8 shifts bits 31..0 right by one, keeps bit 31, and puts old bit 0 into carry. Code 9 rotates bits 31..0 right by one, putting old bit 0 into both carry and bit 31.
- R6: Code A shifts bits 31..0 left by one with a 0 in at bit 0. Code B rotates them left by one. Both put old bit 31 into carry.
- R7: Code F rotates bits 31..0 left by eight, moving bits 31..24 into bits 7..0, and puts old bit 24 into carry.
- R8: Every 32-bit operation (codes 1-5, 8-B, F) copies accumulator bits 47..32 to result bits 47..32. The no-operation codes (0, 7, C, D, E) output the accumulator unchanged.
- R9: A no-operation code leaves all four flags unchanged, even when enabled.
- R10: Overflow, once set, stays set until the synchronous clear input is high at a clock edge. That clear resets overflow and wins over a set in the same cycle.
- R11: With the enable low, carry, zero and sign hold their values. Overflow also holds unless it is cleared.
- R12: While the active-low synchronous reset is low at a clock edge, all four flags become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Flag update enable |
| clr_ovf | input | 1 | Synchronous clear of the sticky overflow flag |
| op | input | 4 | Operation code |
| acc | input | 48 | Accumulator operand |
| prod | input | 48 | Product operand |
| result | output | 48 | Combinational ALU result |
| flag_c | output | 1 | Registered carry flag |
| flag_z | output | 1 | Registered zero flag |
| flag_s | output | 1 | Registered sign flag |
| flag_v | output | 1 | Registered sticky overflow flag |

## Verification
The assertions check four things on every cycle:
- the overflow flag never drops without a clear, and a clear always empties it;
- flags hold when the enable is low or the code is a no-operation;
- logic operations always leave carry clear;
- the upper 16 result bits follow the accumulator for every 32-bit operation.

The arithmetic values themselves can only be shown by the bench's scenarios. These include the carry and borrow bits, the two overflow sign rules, the 48-bit zero that differs from a 32-bit zero, and the carry taken from bit 24 in the byte rotate. The bench's scenarios also cover the priority of the clear over a simultaneous set.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
// Package: acc_alu_pkg
// Shared operation codes, flag record and code classification helpers for
// the accumulator ALU. Assumes a 4-bit operation code.
package acc_alu_pkg;

    localparam logic [3:0] OP_AND  = 4'h1;
    localparam logic [3:0] OP_OR   = 4'h2;
    localparam logic [3:0] OP_XOR  = 4'h3;
    localparam logic [3:0] OP_ADD  = 4'h4;
    localparam logic [3:0] OP_SUB  = 4'h5;
    localparam logic [3:0] OP_ADDW = 4'h6;
    localparam logic [3:0] OP_SRA  = 4'h8;
    localparam logic [3:0] OP_RR   = 4'h9;
    localparam logic [3:0] OP_SL   = 4'hA;
    localparam logic [3:0] OP_RL   = 4'hB;
    localparam logic [3:0] OP_RL8  = 4'hF;

    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic v;
    } alu_flags_t;

    // True for every code that performs work; all others are no-operations.
    function automatic logic op_active(input logic [3:0] op);
        case (op)
            OP_AND, OP_OR, OP_XOR, OP_ADD, OP_SUB, OP_ADDW,
            OP_SRA, OP_RR, OP_SL, OP_RL, OP_RL8: return 1'b1;
            default:                             return 1'b0;
        endcase
    endfunction

    // True for active codes that work on the low word only.
    function automatic logic op_narrow(input logic [3:0] op);
        return op_active(op) && (op != OP_ADDW);
    endfunction

    // True for the codes whose result comes from the adder.
    function automatic logic op_arith(input logic [3:0] op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADDW);
    endfunction

endpackage

// File: rtl/acc_bit_unit.sv
`timescale 1ns/1ps
// Module: acc_bit_unit
// Bitwise logic, single-bit shifts/rotates and the multi-bit left rotate on
// the low word. Purely combinational. Assumes ROT_STEP < W.
// The carry output is 0 for bitwise codes and don't-care for others.
module acc_bit_unit
    import acc_alu_pkg::*;
#(
    parameter int W        = 32,
    parameter int ROT_STEP = 8
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         carry
);

    // Select the bit-level operation and its carry.
    always_comb begin
        res   = a;
        carry = 1'b0;
        case (op)
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_SRA: begin res = {a[W-1], a[W-1:1]}; carry = a[0];   end
            OP_RR:  begin res = {a[0],   a[W-1:1]}; carry = a[0];   end
            OP_SL:  begin res = {a[W-2:0], 1'b0};   carry = a[W-1]; end
            OP_RL:  begin res = {a[W-2:0], a[W-1]}; carry = a[W-1]; end
            OP_RL8: begin
                res   = {a[W-ROT_STEP-1:0], a[W-1:W-ROT_STEP]};
                carry = a[W-ROT_STEP];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/acc_add_unit.sv
`timescale 1ns/1ps
// Module: acc_add_unit
// Narrow add, narrow subtract and full-width add with carry and overflow.
// Purely combinational. Narrow results keep the accumulator's upper bits.
module acc_add_unit
    import acc_alu_pkg::*;
#(
    parameter int ACC_W    = 48,
    parameter int NARROW_W = 32
) (
    input  logic [3:0]       op,
    input  logic [ACC_W-1:0] acc,
    input  logic [ACC_W-1:0] prod,
    output logic [ACC_W-1:0] res,
    output logic             carry,
    output logic             ovf
);

    localparam int HI_W = ACC_W - NARROW_W;

    logic [NARROW_W-1:0] a_lo, b_lo;
    logic [NARROW_W:0]   sum_n, dif_n;
    logic [ACC_W:0]      sum_w;

    assign a_lo  = acc[NARROW_W-1:0];
    assign b_lo  = prod[NARROW_W-1:0];
    assign sum_n = {1'b0, a_lo} + {1'b0, b_lo};
    assign dif_n = {1'b0, a_lo} - {1'b0, b_lo};
    assign sum_w = {1'b0, acc} + {1'b0, prod};

    // Pick the adder variant and apply its sign-based overflow rule.
    always_comb begin
        res   = acc;
        carry = 1'b0;
        ovf   = 1'b0;
        case (op)
            OP_ADD: begin
                res   = {acc[ACC_W-1 -: HI_W], sum_n[NARROW_W-1:0]};
                carry = sum_n[NARROW_W];
                ovf   = ~(a_lo[NARROW_W-1] ^ b_lo[NARROW_W-1])
                        & (a_lo[NARROW_W-1] ^ sum_n[NARROW_W-1]);
            end
            OP_SUB: begin
                res   = {acc[ACC_W-1 -: HI_W], dif_n[NARROW_W-1:0]};
                carry = dif_n[NARROW_W];
                ovf   = (a_lo[NARROW_W-1] ^ b_lo[NARROW_W-1])
                        & (a_lo[NARROW_W-1] ^ dif_n[NARROW_W-1]);
            end
            OP_ADDW: begin
                res   = sum_w[ACC_W-1:0];
                carry = sum_w[ACC_W];
                ovf   = ~(acc[ACC_W-1] ^ prod[ACC_W-1])
                        & (acc[ACC_W-1] ^ sum_w[ACC_W-1]);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/acc_alu_core.sv
`timescale 1ns/1ps
// Module: acc_alu_core
// Combinational ALU: routes the code to the bit unit or the adder and builds
// the candidate flags. Zero/sign come from the low word for narrow codes and
// from the full word for the wide add. The v field of flags_nxt is an
// overflow request only; stickiness lives in the wrapper.
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int ACC_W    = 48,
    parameter int NARROW_W = 32,
    parameter int ROT_STEP = 8
) (
    input  logic [3:0]       op,
    input  logic [ACC_W-1:0] acc,
    input  logic [ACC_W-1:0] prod,
    output logic [ACC_W-1:0] result,
    output alu_flags_t       flags_nxt,
    output logic             upd
);

    localparam int HI_W = ACC_W - NARROW_W;

    logic [NARROW_W-1:0] bit_res;
    logic                bit_c;
    logic [ACC_W-1:0]    add_res;
    logic                add_c, add_v;

    acc_bit_unit #(.W(NARROW_W), .ROT_STEP(ROT_STEP)) u_bit (
        .op    (op),
        .a     (acc[NARROW_W-1:0]),
        .b     (prod[NARROW_W-1:0]),
        .res   (bit_res),
        .carry (bit_c)
    );

    acc_add_unit #(.ACC_W(ACC_W), .NARROW_W(NARROW_W)) u_add (
        .op    (op),
        .acc   (acc),
        .prod  (prod),
        .res   (add_res),
        .carry (add_c),
        .ovf   (add_v)
    );

    // Merge unit outputs into the result and candidate flags.
    always_comb begin
        upd = op_active(op);
        if (op_arith(op)) begin
            result      = add_res;
            flags_nxt.c = add_c;
            flags_nxt.v = add_v;
        end else if (upd) begin
            result      = {acc[ACC_W-1 -: HI_W], bit_res};
            flags_nxt.c = bit_c;
            flags_nxt.v = 1'b0;
        end else begin
            result      = acc;
            flags_nxt.c = 1'b0;
            flags_nxt.v = 1'b0;
        end
        if (op == OP_ADDW) begin
            flags_nxt.z = ~|result;
            flags_nxt.s = result[ACC_W-1];
        end else begin
            flags_nxt.z = ~|result[NARROW_W-1:0];
            flags_nxt.s = result[NARROW_W-1];
        end
    end

endmodule

// File: rtl/acc_flag_alu.sv
`timescale 1ns/1ps
// Module: acc_flag_alu
// Top: combinational accumulator ALU plus the registered flag bank.
// Carry/zero/sign load on enabled active codes; overflow is sticky and is
// cleared only by clr_ovf, which wins over a same-cycle set.
// Assumes synchronous active-low reset.
module acc_flag_alu
    import acc_alu_pkg::*;
#(
    parameter int ACC_W    = 48,
    parameter int NARROW_W = 32,
    parameter int ROT_STEP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr_ovf,
    input  logic [3:0]       op,
    input  logic [ACC_W-1:0] acc,
    input  logic [ACC_W-1:0] prod,
    output logic [ACC_W-1:0] result,
    output logic             flag_c,
    output logic             flag_z,
    output logic             flag_s,
    output logic             flag_v
);

    alu_flags_t flags_nxt, flags_q;
    logic       upd;

    acc_alu_core #(.ACC_W(ACC_W), .NARROW_W(NARROW_W), .ROT_STEP(ROT_STEP)) u_core (
        .op        (op),
        .acc       (acc),
        .prod      (prod),
        .result    (result),
        .flags_nxt (flags_nxt),
        .upd       (upd)
    );

    // Flag bank: load c/z/s on enabled work, accumulate or clear overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            if (en && upd) begin
                flags_q.c <= flags_nxt.c;
                flags_q.z <= flags_nxt.z;
                flags_q.s <= flags_nxt.s;
            end
            if (clr_ovf)
                flags_q.v <= 1'b0;
            else if (en && upd)
                flags_q.v <= flags_q.v | flags_nxt.v;
        end
    end

    assign flag_c = flags_q.c;
    assign flag_z = flags_q.z;
    assign flag_s = flags_q.s;
    assign flag_v = flags_q.v;

    // R10: overflow never drops without a clear
    p_sticky_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && flag_v && !clr_ovf) |=> flag_v);

    // R10: a clear always empties overflow, even against a set
    p_clear_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && clr_ovf) |=> !flag_v);

    // R11: flags hold while the enable is low
    p_hold_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !en && !clr_ovf) |=> $stable({flag_c, flag_z, flag_s, flag_v}));

    // R9: no-operation codes keep the flags
    p_nop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && en && !clr_ovf && !op_active(op))
        |=> $stable({flag_c, flag_z, flag_s, flag_v}));

    // R1: bitwise codes leave carry clear
    p_logic_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && en && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=> !flag_c);

    // R8: upper bits follow the accumulator on narrow codes
    p_upper_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_narrow(op) || !op_active(op))
        |-> result[ACC_W-1:NARROW_W] == acc[ACC_W-1:NARROW_W]);

endmodule

// File: tb/acc_flag_alu_test.sv
`timescale 1ns/1ps
module acc_flag_alu_test;

    typedef struct packed {
        logic [3:0]  op;
        logic [47:0] acc;
        logic [47:0] prod;
        logic [47:0] res;
        logic [3:0]  flg;   // {c, z, s, v}
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [0:NV-1] = '{
        '{4'h1, 48'h1234_F0F0_FF00, 48'h0000_0FF0_F0F0, 48'h1234_00F0_F000, 4'b0000}, // R1 AND
        '{4'h2, 48'hABCD_8000_0000, 48'h0000_0000_0001, 48'hABCD_8000_0001, 4'b0010}, // R1 OR
        '{4'h3, 48'h0001_5555_5555, 48'hFFFF_5555_5555, 48'h0001_0000_0000, 4'b0100}, // R1 XOR zero
        '{4'h4, 48'h0000_FFFF_FFFF, 48'h0000_0000_0001, 48'h0000_0000_0000, 4'b1100}, // R2 carry
        '{4'h4, 48'h0000_7FFF_FFFF, 48'h0000_0000_0001, 48'h0000_8000_0000, 4'b0011}, // R2 overflow
        '{4'h5, 48'h00AA_0000_0001, 48'h0000_0000_0002, 48'h00AA_FFFF_FFFF, 4'b1010}, // R3 borrow
        '{4'h5, 48'h0000_8000_0000, 48'h0000_0000_0001, 48'h0000_7FFF_FFFF, 4'b0001}, // R3 overflow
        '{4'h6, 48'h7FFF_FFFF_FFFF, 48'h0000_0000_0001, 48'h8000_0000_0000, 4'b0011}, // R4 overflow
        '{4'h6, 48'hFFFF_FFFF_FFFF, 48'h0000_0000_0001, 48'h0000_0000_0000, 4'b1100}, // R4 carry
        '{4'h6, 48'h0000_FFFF_FFFF, 48'h0000_0000_0001, 48'h0001_0000_0000, 4'b0000}, // R4 no bit32 carry
        '{4'h8, 48'h1111_8000_0003, 48'hFFFF_FFFF_FFFF, 48'h1111_C000_0001, 4'b1010}, // R5 SRA
        '{4'h9, 48'h0000_0000_0001, 48'hFFFF_FFFF_FFFF, 48'h0000_8000_0000, 4'b1010}, // R5 RR
        '{4'hA, 48'h2222_C000_0001, 48'hFFFF_FFFF_FFFF, 48'h2222_8000_0002, 4'b1010}, // R6 SL
        '{4'hA, 48'h0000_8000_0000, 48'h0000_0000_0000, 48'h0000_0000_0000, 4'b1100}, // R6 SL zero
        '{4'hB, 48'h0000_8000_0000, 48'hFFFF_FFFF_FFFF, 48'h0000_0000_0001, 4'b1000}, // R6 RL
        '{4'hF, 48'h3333_1234_5678, 48'hFFFF_FFFF_FFFF, 48'h3333_3456_7812, 4'b0000}, // R7 RL8
        '{4'hF, 48'h0000_0100_0000, 48'h0000_0000_0000, 48'h0000_0000_0001, 4'b1000}, // R7 bit24 carry
        '{4'hF, 48'h0000_8000_0000, 48'h0000_0000_0000, 48'h0000_0000_0080, 4'b0000}  // R7/R8 top byte
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        clr_ovf = 1'b0;
    logic [3:0]  op = 4'h0;
    logic [47:0] acc = '0;
    logic [47:0] prod = '0;
    logic [47:0] result;
    logic        flag_c, flag_z, flag_s, flag_v;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    acc_flag_alu uut (
        .clk(clk), .rst_n(rst_n), .en(en), .clr_ovf(clr_ovf), .op(op),
        .acc(acc), .prod(prod), .result(result),
        .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_v(flag_v)
    );

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [47:0] flags4();
        return {44'd0, flag_c, flag_z, flag_s, flag_v};
    endfunction

    // Drive inputs on the falling edge, then step past the next rising edge.
    task automatic cycle(input logic [3:0] o, input logic [47:0] a, input logic [47:0] p,
                         input logic e, input logic c);
        @(negedge clk);
        op = o; acc = a; prod = p; en = e; clr_ovf = c;
        #1;
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R12: reset state
        cycle(4'h0, '0, '0, 1'b0, 1'b0);
        settle();
        settle();
        check("R12 reset flags", flags4(), 48'h0);
        rst_n = 1'b1;

        // Table walk: clear overflow, then one enabled operation
        for (int i = 0; i < NV; i++) begin
            cycle(4'h0, '0, '0, 1'b0, 1'b1);
            settle();
            cycle(VECS[i].op, VECS[i].acc, VECS[i].prod, 1'b1, 1'b0);
            check($sformatf("R1-8 vec%0d result", i), result, VECS[i].res);
            settle();
            check($sformatf("R1-8 vec%0d flags", i), flags4(), {44'd0, VECS[i].flg});
        end

        // R10: overflow stays set across an operation without overflow
        cycle(4'h0, '0, '0, 1'b0, 1'b1); settle();
        cycle(4'h4, 48'h0000_7FFF_FFFF, 48'h1, 1'b1, 1'b0); settle();
        cycle(4'h1, 48'h0000_0000_000F, 48'h0000_0000_0003, 1'b1, 1'b0); settle();
        check("R10 sticky after AND", flags4(), 48'b0001);

        // R10: clear alone
        cycle(4'h0, '0, '0, 1'b0, 1'b1); settle();
        check("R10 clear", flags4(), 48'b0000);

        // R10: clear wins over same-cycle set; c/z/s still load
        cycle(4'h4, 48'h0000_7FFF_FFFF, 48'h1, 1'b1, 1'b1); settle();
        check("R10 clear priority", flags4(), 48'b0010);

        // R11: enable low holds flags
        cycle(4'h4, 48'h0000_FFFF_FFFF, 48'h1, 1'b0, 1'b0); settle();
        check("R11 hold when disabled", flags4(), 48'b0010);
        cycle(4'h4, 48'h0000_7FFF_FFFF, 48'h1, 1'b0, 1'b0); settle();
        check("R11 no overflow when disabled", flags4(), 48'b0010);

        // R9 / R8: no-operation codes keep flags and pass acc
        cycle(4'h4, 48'h0000_FFFF_FFFF, 48'h1, 1'b1, 1'b0); settle();
        check("R9 preload", flags4(), 48'b1100);
        cycle(4'h0, 48'h5A5A_1234_5678, 48'hFFFF_FFFF_FFFF, 1'b1, 1'b0);
        check("R8 nop0 result", result, 48'h5A5A_1234_5678);
        settle();
        check("R9 nop0 flags", flags4(), 48'b1100);
        cycle(4'h7, 48'h8000_0000_0000, 48'h7FFF_FFFF_FFFF, 1'b1, 1'b0);
        check("R8 nop7 result", result, 48'h8000_0000_0000);
        settle();
        check("R9 nop7 flags", flags4(), 48'b1100);
        cycle(4'hC, 48'h0000_0000_0001, 48'h1, 1'b1, 1'b0);
        check("R8 nopC result", result, 48'h0000_0000_0001);
        settle();
        check("R9 nopC flags", flags4(), 48'b1100);

        // R12: reset in mid-run clears flags
        cycle(4'h4, 48'h0000_7FFF_FFFF, 48'h1, 1'b1, 1'b0); settle();
        rst_n = 1'b0;
        cycle(4'h0, '0, '0, 1'b0, 1'b0); settle();
        check("R12 mid-run reset", flags4(), 48'h0);
        rst_n = 1'b1;

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule